// File: doc/BRIEF.md
# Time-Sliced Shared SRAM Arbiter

This block lets a single single-port SRAM hold both the program memory of an 8-bit CPU and the display memory read by a video fetch unit. No separate video RAM is needed. The fast system clock splits memory time into slots of one system clock each. Even slots belong to the CPU and odd slots to the video reader, and the pattern never changes. Both requesters are served at a rate well above their own access rate. Neither of them ever waits, and the video side can never be starved, so contention noise on the screen cannot occur.

The block also divides the system clock by a parameter (28 by default, so 50 MHz becomes about 1.79 MHz) and produces a CPU clock enable. A CPU memory write is captured once per CPU period and committed in exactly one CPU slot. The block returns latched read data to each requester. CPU I/O cycles are decoded from the low address byte only, so the upper byte the CPU places on the bus (0x00 or 0xFF, depending on the CPU variant) has no effect.

Top module: `sram_slot_arbiter`

## Requirements
- R1: `cpu_ce` is high for exactly one system clock in every `CPU_DIV` (28) clocks. After reset is released, the first cycle is numbered k=0, and `cpu_ce` is high when k mod 28 equals 27.
- R2: In cycle k, an even k is a CPU slot and an odd k is a video slot. In a CPU slot that is not a write, `sram_addr` equals `cpu_addr`. In a video slot, `sram_addr` equals `vid_addr`.
- R3: Outside reset, `sram_cs_n` is 0 in every slot. `sram_oe_n` is 0 in every slot except a write slot, where it is 1.
- R4: When `cpu_ce` is high, `cpu_wr` is 1 and `cpu_iorq` is 0, the address and data are captured. The write is performed in the next cycle, which is always a CPU slot (k mod 28 = 0). In that cycle `sram_we_n` is 0 and `sram_addr`/`sram_wdata` show the captured values.
- R5: `sram_we_n` goes low at most once per CPU period, however long `cpu_wr` stays high. A `cpu_wr` that is high only while `cpu_ce` is low causes no write.
- R6: `cpu_rdata` takes `sram_rdata` at the end of every CPU slot that is not a write slot. It holds through video slots and write slots.
- R7: `vid_rdata` takes `sram_rdata` at the end of every video slot and holds through CPU slots.
- R8: `io_sel[i]` is 1 exactly when `cpu_iorq` is 1 and `cpu_addr[7:0]` equals `IO_BASE`+i (0x10..0x13 by default). `cpu_addr[15:8]` is ignored.
- R9: A write request with `cpu_iorq` high never writes the SRAM.
- R10: While `rst` is high, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are 1, `cpu_ce` is 0, and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | output | 1 | One-clock CPU clock enable pulse |
| cpu_addr | input | ADDR_W | CPU address (memory or I/O) |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_wr | input | 1 | CPU write request |
| cpu_iorq | input | 1 | CPU cycle is an I/O access |
| cpu_rdata | output | DATA_W | Latched CPU read data |
| io_sel | output | NUM_IO | One select per decoded I/O port |
| vid_addr | input | ADDR_W | Video fetch address |
| vid_rdata | output | DATA_W | Latched video read data |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The slot machinery is first driven with pure reads, with the video address sweeping and the CPU address random. This separates the address mux and the two read latches from any write effect. A CPU write request held high across whole periods, and one raised on every cycle except the enable cycle, shows whether writes are sampled only at the enable and committed exactly once. I/O cycles with both upper-byte values and low bytes around the port window check the decoder and show that I/O writes stay out of memory. A final mixed random phase checks that the read-after-write results seen by both requesters agree with the reference memory.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

  typedef enum logic {
    SLOT_CPU = 1'b0,
    SLOT_VID = 1'b1
  } slot_e;

  // Next value of a modulo-div counter.
  function automatic int unsigned div_next(input int unsigned cur, input int unsigned div);
    return (cur == div - 1) ? 0 : cur + 1;
  endfunction

  // True when the low address byte selects port idx above base.
  function automatic logic port_hit(input logic [7:0] lo, input logic [7:0] base,
                                    input int unsigned idx);
    return lo == (base + 8'(idx));
  endfunction

  function automatic slot_e slot_flip(input slot_e s);
    return (s == SLOT_CPU) ? SLOT_VID : SLOT_CPU;
  endfunction

endpackage

// File: rtl/arb_clk_div.sv
module arb_clk_div #(
  parameter int unsigned DIV = 28
) (
  input  logic clk,
  input  logic rst,
  output logic ce
);
  import sram_arb_pkg::*;

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= CW'(div_next(32'(cnt), DIV));
  end

  assign ce = ~rst && (32'(cnt) == DIV - 1);

endmodule

// File: rtl/arb_slot_seq.sv
module arb_slot_seq (
  input  logic                clk,
  input  logic                rst,
  output sram_arb_pkg::slot_e slot
);
  import sram_arb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) slot <= SLOT_CPU;
    else     slot <= slot_flip(slot);
  end

endmodule

// File: rtl/arb_io_decode.sv
module arb_io_decode #(
  parameter int unsigned NUM_IO  = 4,
  parameter logic [7:0]  IO_BASE = 8'h10
) (
  input  logic              iorq,
  input  logic [7:0]        port_lo,
  output logic [NUM_IO-1:0] sel
);
  import sram_arb_pkg::*;

  for (genvar i = 0; i < NUM_IO; i++) begin : g_port
    assign sel[i] = iorq && port_hit(port_lo, IO_BASE, i);
  end

endmodule

// File: rtl/sram_slot_arbiter.sv
module sram_slot_arbiter #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CPU_DIV = 28,
  parameter int unsigned NUM_IO  = 4,
  parameter logic [7:0]  IO_BASE = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cpu_ce,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_iorq,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [NUM_IO-1:0] io_sel,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [DATA_W-1:0] vid_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  import sram_arb_pkg::*;

  slot_e slot;

  // Named internal events, also used by the bound checker.
  logic cpu_slot;   // current slot belongs to the CPU
  logic wr_take;    // write request captured at the CPU enable
  logic wr_slot;    // current slot commits the pending write

  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  arb_clk_div #(.DIV(CPU_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .ce  (cpu_ce)
  );

  arb_slot_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .slot (slot)
  );

  arb_io_decode #(.NUM_IO(NUM_IO), .IO_BASE(IO_BASE)) u_io (
    .iorq    (cpu_iorq),
    .port_lo (cpu_addr[7:0]),
    .sel     (io_sel)
  );

  assign cpu_slot = (slot == SLOT_CPU);
  assign wr_take  = cpu_ce && cpu_wr && !cpu_iorq;
  assign wr_slot  = !rst && cpu_slot && wr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      if (wr_slot) wr_pend <= 1'b0;
      if (wr_take) begin
        wr_pend <= 1'b1;
        wr_addr <= cpu_addr;
        wr_data <= cpu_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      vid_rdata <= '0;
    end else if (cpu_slot) begin
      if (!wr_slot) cpu_rdata <= sram_rdata;
    end else begin
      vid_rdata <= sram_rdata;
    end
  end

  always_comb begin
    if (wr_slot)       sram_addr = wr_addr;
    else if (cpu_slot) sram_addr = cpu_addr;
    else               sram_addr = vid_addr;
  end

  assign sram_wdata = wr_data;
  assign sram_cs_n  = rst;
  assign sram_oe_n  = rst || wr_slot;
  assign sram_we_n  = !wr_slot;

endmodule

// File: rtl/sram_arb_checker.sv
module sram_arb_checker #(
  parameter int unsigned DIV    = 28,
  parameter int unsigned NUM_IO = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ce,
  input logic              cpu_slot,
  input logic              sram_cs_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic [DATA_W-1:0] vid_rdata,
  input logic [NUM_IO-1:0] io_sel
);

  int unsigned gap;   // clocks since the last enable
  int unsigned wcnt;  // writes since the last enable

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 0;
      wcnt <= 0;
    end else begin
      gap <= cpu_ce ? 0 : gap + 1;
      if (cpu_ce)          wcnt <= 0;
      else if (!sram_we_n) wcnt <= wcnt + 1;
    end
  end

  assert_ce_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |-> gap == DIV - 1);
  assert_ce_due_R1: assert property (@(posedge clk) disable iff (rst)
    gap == DIV - 1 |-> cpu_ce);
  assert_cpu_then_vid_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_slot |=> !cpu_slot);
  assert_vid_then_cpu_R2: assert property (@(posedge clk) disable iff (rst)
    !cpu_slot |=> cpu_slot);
  assert_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    !sram_cs_n && (sram_oe_n != sram_we_n));
  assert_we_cpu_slot_R4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> cpu_slot);
  assert_one_write_R5: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> wcnt == 0);
  assert_cpu_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cpu_slot |=> $stable(cpu_rdata));
  assert_vid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_slot |=> $stable(vid_rdata));
  assert_io_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(io_sel));

endmodule

bind sram_slot_arbiter sram_arb_checker #(
  .DIV    (CPU_DIV),
  .NUM_IO (NUM_IO),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_ce    (cpu_ce),
  .cpu_slot  (cpu_slot),
  .sram_cs_n (sram_cs_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .cpu_rdata (cpu_rdata),
  .vid_rdata (vid_rdata),
  .io_sel    (io_sel)
);

// File: tb/test_sram_slot_arbiter.sv
module test_sram_slot_arbiter;

  localparam int NCYC = 1400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_ce;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_iorq = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [3:0]  io_sel;
  logic [15:0] vid_addr = '0;
  logic [7:0]  vid_rdata;
  logic [15:0] sram_addr;
  logic [7:0]  sram_wdata;
  logic [7:0]  sram_rdata;
  logic        sram_cs_n, sram_oe_n, sram_we_n;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sram_slot_arbiter i_sram_slot_arbiter (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_iorq(cpu_iorq),
    .cpu_rdata(cpu_rdata), .io_sel(io_sel),
    .vid_addr(vid_addr), .vid_rdata(vid_rdata),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  // Behavioural SRAM, decoding the low address byte.
  logic [7:0] sram_mem [256];
  logic [7:0] ref_mem  [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      sram_mem[i] = 8'(i * 7 + 8'h3C);
      ref_mem[i]  = 8'(i * 7 + 8'h3C);
    end
  end

  always_comb sram_rdata = (!sram_cs_n && !sram_oe_n) ? sram_mem[sram_addr[7:0]] : 8'h00;

  always @(posedge clk)
    if (!sram_cs_n && !sram_we_n) sram_mem[sram_addr[7:0]] <= sram_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input int k);
    int m;
    m = k / 280;
    cpu_wr   = 1'b0;
    cpu_iorq = 1'b0;
    cpu_addr = 16'($urandom_range(0, 63));
    cpu_wdata = 8'($urandom);
    vid_addr = 16'(k % 64);
    case (m)
      1: cpu_wr = 1'b1;
      2: cpu_wr = (k % 28 != 27);
      3: begin
        cpu_iorq = 1'b1;
        cpu_wr   = 1'($urandom % 2);
        cpu_addr = {(($urandom % 2) != 0) ? 8'hFF : 8'h00, 8'(14 + $urandom_range(0, 7))};
      end
      4: begin
        cpu_wr   = (($urandom % 3) == 0);
        cpu_iorq = (($urandom % 4) == 0);
        if (cpu_iorq) cpu_addr = {8'hFF, 8'(14 + $urandom_range(0, 7))};
        vid_addr = 16'($urandom_range(0, 63));
      end
      default: ;
    endcase
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int          k;
    bit          pend;
    logic [15:0] wa;
    logic [7:0]  wd;
    logic [7:0]  exp_cr, exp_vr;
    logic [3:0]  exp_io;
    bit          ece, cslot, ewe;
    string       wtag;
    k = 0; pend = 0; wa = '0; wd = '0; exp_cr = '0; exp_vr = '0;

    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      chk(sram_cs_n == 1'b1, "R10 cs_n", 32'(sram_cs_n), 1);
      chk(sram_oe_n == 1'b1, "R10 oe_n", 32'(sram_oe_n), 1);
      chk(sram_we_n == 1'b1, "R10 we_n", 32'(sram_we_n), 1);
      chk(cpu_ce == 1'b0, "R10 cpu_ce", 32'(cpu_ce), 0);
      chk(cpu_rdata == 8'h00 && vid_rdata == 8'h00, "R10 rdata",
          {16'h0, cpu_rdata, vid_rdata}, 0);
    end

    @(posedge clk);
    #2;
    rst = 1'b0;
    drive(0);

    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      ece   = (k % 28 == 27);
      cslot = (k % 2 == 0);
      ewe   = cslot && pend;
      wtag  = (k / 280 == 3) ? "R9" : ((k / 280 == 1 || k / 280 == 2) ? "R5" : "R4");

      chk(cpu_ce == ece, "R1 cpu_ce", 32'(cpu_ce), 32'(ece));
      chk(sram_cs_n == 1'b0, "R3 cs_n", 32'(sram_cs_n), 0);
      chk(sram_oe_n == ewe, "R3 oe_n", 32'(sram_oe_n), 32'(ewe));
      chk(sram_we_n == !ewe, {wtag, " we_n"}, 32'(sram_we_n), 32'(!ewe));
      if (ewe) begin
        chk(sram_addr == wa, "R4 write addr", 32'(sram_addr), 32'(wa));
        chk(sram_wdata == wd, "R4 write data", 32'(sram_wdata), 32'(wd));
      end else if (cslot) begin
        chk(sram_addr == cpu_addr, "R2 cpu addr", 32'(sram_addr), 32'(cpu_addr));
      end else begin
        chk(sram_addr == vid_addr, "R2 vid addr", 32'(sram_addr), 32'(vid_addr));
      end
      chk(cpu_rdata == exp_cr, "R6 cpu_rdata", 32'(cpu_rdata), 32'(exp_cr));
      chk(vid_rdata == exp_vr, "R7 vid_rdata", 32'(vid_rdata), 32'(exp_vr));
      for (int i = 0; i < 4; i++)
        exp_io[i] = cpu_iorq && (cpu_addr[7:0] == 8'(8'h10 + i));
      chk(io_sel == exp_io, "R8 io_sel", 32'(io_sel), 32'(exp_io));

      // Reference model: effect of the coming clock edge
      if (ewe)        ref_mem[wa[7:0]] = wd;
      else if (cslot) exp_cr = ref_mem[cpu_addr[7:0]];
      else            exp_vr = ref_mem[vid_addr[7:0]];
      if (ewe) pend = 0;
      if (ece && cpu_wr && !cpu_iorq) begin
        pend = 1;
        wa   = cpu_addr;
        wd   = cpu_wdata;
      end
      k++;

      @(posedge clk);
      #2;
      drive(k);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule